// File: doc/BRIEF.md
# Timed Preamble and Separator Detector

This block sits behind the slicer of an on-off-keyed wake-up receiver and judges the digitized baseband line while the listening window is open. It accepts an alternating 0101… preamble only when each rising edge arrives a bounded number of clock cycles after the one before it. An interferer whose baseband rate is too fast or too slow therefore fails on edge timing rather than on bit pattern. Rising edges are counted, and the preamble is declared good once a programmed number of them has been seen.

After a good preamble the detector samples the line at mid-bit and waits for a programmed run of consecutive '1' bits, the separator. The first falling edge after that run marks the start bit of the address field. A one-cycle pulse then tells the address correlator to begin.

Any timing violation during preamble counting produces a one-cycle reject pulse and sends the detector back to idle with its count cleared. Dropping `enable` closes the listening window and clears all state silently. The serial line passes through a two-flop synchronizer before any edge is taken from it.

Top module: `wake_preamble_gate`

## Requirements
- R1: After reset, and while `enable` is low, `preamble_ok`, `separator_ok`, `start_detected` and `reject` are all 0.
- R2: A rising edge is accepted when it follows the previous rising edge by a number of cycles in the inclusive range `cfg_win_min`..`cfg_win_max`. `preamble_ok` goes to 1 when the count of rising edges, the first one included, reaches `cfg_edges`, and not before.
- R3: While edges are being counted, a rising edge that arrives fewer than `cfg_win_min` cycles after the previous one causes a reject.
- R4: While edges are being counted, if no rising edge has arrived `cfg_win_max` cycles after the previous one, the detector rejects, so a spacing of `cfg_win_max`+1 or more fails.
- R5: A reject is a single-cycle pulse on `reject`, and the detector returns to idle. The next preamble must again supply `cfg_edges` fresh rising edges.
- R6: After `preamble_ok`, the line is sampled once per bit of `cfg_bit_len` cycles. The first sample falls `cfg_bit_len`/2 cycles after each rising edge, so the sampling phase re-aligns on every rising edge. `separator_ok` goes to 1 after `cfg_sep_bits` consecutive samples read 1, and a sample reading 0 clears the run.
- R7: `start_detected` pulses for one cycle on the first falling edge after `separator_ok` is set. A falling edge seen before `separator_ok` produces no pulse.
- R8: Lowering `enable` returns the detector to idle without a reject pulse.
- R9: Once the start bit has been found, `preamble_ok` and `separator_ok` stay at 1 and no further start pulse occurs until `enable` is lowered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Listening window open |
| rx_in | input | 1 | Asynchronous digitized baseband line |
| cfg_edges | input | EDGE_W | Rising edges needed for a good preamble |
| cfg_sep_bits | input | RUN_W | Consecutive 1 bits forming the separator |
| cfg_win_min | input | CNT_W | Shortest accepted edge spacing, in cycles |
| cfg_win_max | input | CNT_W | Longest accepted edge spacing, in cycles |
| cfg_bit_len | input | CNT_W | Bit period, in cycles |
| preamble_ok | output | 1 | Preamble accepted |
| separator_ok | output | 1 | Separator run complete |
| start_detected | output | 1 | One-cycle pulse at the start bit |
| reject | output | 1 | One-cycle pulse on a preamble timing violation |

## Verification
The bench places edge spacings at both window limits and one cycle outside each. An off-by-one in the gap counter would then either reject a legal rate or pass a bad one. It runs the same number of edges after a reject, to catch a count that survives the reject and declares the preamble early. It sends a separator one bit short followed by a 0, where a run counter that fails to clear, or a start detector that does not wait for the separator, would raise a false start. Finally it closes the window after a complete frame: the outputs must clear with no reject pulse, and the flags must hold with no second start pulse until then.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SEP,
    ST_WAIT0,
    ST_DONE
  } pd_state_e;
endpackage

// File: rtl/pd_rst_sync.sv
module pd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pd_sync2.sv
module pd_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out,
  output logic q_prev
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-1:0], d_in};
  end

  assign q_out  = pipe_q[STAGES-1];
  assign q_prev = pipe_q[STAGES];
endmodule

// File: rtl/pd_gap_timer.sv
module pd_gap_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             count_en,
  input  logic [CNT_W-1:0] win_min,
  input  logic [CNT_W-1:0] win_max,
  output logic             in_window,
  output logic             expired
);
  localparam logic [CNT_W-1:0] GAP_ONE = CNT_W'(1);

  logic [CNT_W-1:0] gap_q, gap_d;

  always_comb begin
    gap_d = gap_q;
    if (restart)                     gap_d = GAP_ONE;
    else if (count_en && gap_q != '1) gap_d = gap_q + GAP_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else        gap_q <= gap_d;
  end

  assign in_window = (gap_q >= win_min) && (gap_q <= win_max);
  assign expired   = (gap_q >= win_max);
endmodule

// File: rtl/pd_bit_sampler.sv
module pd_bit_sampler #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resync,
  input  logic             active,
  input  logic [CNT_W-1:0] bit_len,
  output logic             strobe
);
  localparam logic [CNT_W-1:0] PH_ONE = CNT_W'(1);

  logic [CNT_W-1:0] ph_q, ph_d;

  assign strobe = active && !resync && (ph_q == '0);

  always_comb begin
    ph_d = ph_q;
    if (resync)            ph_d = bit_len >> 1;
    else if (active) begin
      if (ph_q == '0)      ph_d = bit_len - PH_ONE;
      else                 ph_d = ph_q - PH_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/wake_preamble_gate.sv
module wake_preamble_gate
  import pd_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int EDGE_W = 4,
  parameter int RUN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              rx_in,
  input  logic [EDGE_W-1:0] cfg_edges,
  input  logic [RUN_W-1:0]  cfg_sep_bits,
  input  logic [CNT_W-1:0]  cfg_win_min,
  input  logic [CNT_W-1:0]  cfg_win_max,
  input  logic [CNT_W-1:0]  cfg_bit_len,
  output logic              preamble_ok,
  output logic              separator_ok,
  output logic              start_detected,
  output logic              reject
);
  localparam logic [EDGE_W:0] EDGE_ONE = (EDGE_W+1)'(1);
  localparam logic [RUN_W:0]  RUN_ONE  = (RUN_W+1)'(1);

  logic rst_i_n;
  logic line, line_prev, rise, fall;
  logic in_window, expired, strobe;

  pd_state_e       state_q, state_d;
  logic [EDGE_W:0] edges_q, edges_d;
  logic [RUN_W:0]  run_q, run_d;
  logic            rej_q, rej_d;
  logic            start_q, start_d;

  pd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  pd_sync2 #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .d_in(rx_in), .q_out(line), .q_prev(line_prev)
  );

  assign rise = line && !line_prev;
  assign fall = !line && line_prev;

  pd_gap_timer #(.CNT_W(CNT_W)) u_gap (
    .clk(clk), .rst_n(rst_i_n),
    .restart(rise && (state_q == ST_IDLE || state_q == ST_PRE)),
    .count_en(state_q == ST_PRE),
    .win_min(cfg_win_min), .win_max(cfg_win_max),
    .in_window(in_window), .expired(expired)
  );

  pd_bit_sampler #(.CNT_W(CNT_W)) u_smp (
    .clk(clk), .rst_n(rst_i_n),
    .resync(rise), .active(state_q == ST_SEP),
    .bit_len(cfg_bit_len), .strobe(strobe)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    edges_d = edges_q;
    run_d   = run_q;
    rej_d   = 1'b0;
    start_d = 1'b0;
    if (!enable) begin
      state_d = ST_IDLE;
      edges_d = '0;
      run_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          run_d = '0;
          if (rise) begin
            edges_d = EDGE_ONE;
            state_d = (EDGE_ONE >= {1'b0, cfg_edges}) ? ST_SEP : ST_PRE;
          end
        end
        ST_PRE: begin
          if (rise && in_window) begin
            edges_d = edges_q + EDGE_ONE;
            if (edges_q + EDGE_ONE >= {1'b0, cfg_edges}) state_d = ST_SEP;
          end else if (rise || expired) begin
            rej_d   = 1'b1;
            state_d = ST_IDLE;
            edges_d = '0;
          end
        end
        ST_SEP: begin
          if (strobe) begin
            if (line) begin
              run_d = run_q + RUN_ONE;
              if (run_q + RUN_ONE >= {1'b0, cfg_sep_bits}) state_d = ST_WAIT0;
            end else begin
              run_d = '0;
            end
          end
        end
        ST_WAIT0: begin
          if (fall) begin
            start_d = 1'b1;
            state_d = ST_DONE;
          end
        end
        default: state_d = ST_DONE;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      edges_q <= '0;
      run_q   <= '0;
      rej_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      edges_q <= edges_d;
      run_q   <= run_d;
      rej_q   <= rej_d;
      start_q <= start_d;
    end
  end

  assign preamble_ok    = (state_q == ST_SEP) || (state_q == ST_WAIT0) || (state_q == ST_DONE);
  assign separator_ok   = (state_q == ST_WAIT0) || (state_q == ST_DONE);
  assign start_detected = start_q;
  assign reject         = rej_q;
endmodule

// File: rtl/pd_checker.sv
module pd_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic preamble_ok,
  input logic separator_ok,
  input logic start_detected,
  input logic reject
);
  AST_REJECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> !reject); // R5

  AST_REJECT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !preamble_ok && !separator_ok); // R5

  AST_SEP_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    separator_ok |-> preamble_ok); // R6

  AST_START_AFTER_SEP: assert property (@(posedge clk) disable iff (!rst_n)
    start_detected |-> separator_ok); // R7

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_detected |=> !start_detected); // R9

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (separator_ok && enable) |=> separator_ok); // R9

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !preamble_ok && !separator_ok && !reject && !start_detected); // R8

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reject, start_detected})); // R1
endmodule

bind wake_preamble_gate pd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .preamble_ok(preamble_ok), .separator_ok(separator_ok),
  .start_detected(start_detected), .reject(reject)
);

// File: tb/wake_preamble_gate_tb.sv
module wake_preamble_gate_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       rx_in = 1'b0;
  logic [3:0] cfg_edges = 4'd4;
  logic [3:0] cfg_sep_bits = 4'd3;
  logic [7:0] cfg_win_min = 8'd12;
  logic [7:0] cfg_win_max = 8'd20;
  logic [7:0] cfg_bit_len = 8'd8;
  logic preamble_ok, separator_ok, start_detected, reject;

  int checks = 0;
  int errors = 0;
  int rej_cnt = 0;
  int start_cnt = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wake_preamble_gate u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rx_in(rx_in),
    .cfg_edges(cfg_edges), .cfg_sep_bits(cfg_sep_bits),
    .cfg_win_min(cfg_win_min), .cfg_win_max(cfg_win_max),
    .cfg_bit_len(cfg_bit_len),
    .preamble_ok(preamble_ok), .separator_ok(separator_ok),
    .start_detected(start_detected), .reject(reject)
  );

  always @(negedge clk) begin
    if (reject) rej_cnt++;
    if (start_detected) start_cnt++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic train(input int spacing, input int count);
    for (int i = 0; i < count; i++) begin
      rx_in = 1'b1; wait_n(spacing / 2);
      rx_in = 1'b0; wait_n(spacing - spacing / 2);
    end
  endtask

  task automatic reopen();
    enable = 1'b0; rx_in = 1'b0; wait_n(4);
    enable = 1'b1; wait_n(4);
  endtask

  task automatic t_reset();
    chk("R1 preamble_ok after reset", int'(preamble_ok), 0);
    chk("R1 separator_ok after reset", int'(separator_ok), 0);
    chk("R1 pulses after reset", int'(reject) + int'(start_detected), 0);
  endtask

  task automatic t_good_frame();
    int r0, s0;
    reopen();
    r0 = rej_cnt; s0 = start_cnt;
    train(16, 3);
    chk("R2 preamble_ok before n edges", int'(preamble_ok), 0);
    train(16, 1);
    chk("R2 preamble_ok at n edges", int'(preamble_ok), 1);
    rx_in = 1'b1; wait_n(16);
    chk("R6 separator_ok one bit short", int'(separator_ok), 0);
    wait_n(8);
    rx_in = 1'b0; wait_n(6);
    chk("R6 separator_ok after j ones", int'(separator_ok), 1);
    chk("R7 start pulse count", start_cnt - s0, 1);
    wait_n(30);
    rx_in = 1'b1; wait_n(8); rx_in = 1'b0; wait_n(8);
    chk("R9 preamble_ok held", int'(preamble_ok), 1);
    chk("R9 separator_ok held", int'(separator_ok), 1);
    chk("R9 no second start", start_cnt - s0, 1);
    chk("R2 no reject on good frame", rej_cnt - r0, 0);
    r0 = rej_cnt;
    enable = 1'b0; wait_n(3);
    chk("R8 flags cleared", int'(preamble_ok) + int'(separator_ok), 0);
    chk("R8 no reject on disable", rej_cnt - r0, 0);
    chk("R1 outputs low while disabled", int'(reject) + int'(start_detected), 0);
  endtask

  task automatic t_short_separator();
    int s0;
    reopen();
    s0 = start_cnt;
    train(16, 4);
    rx_in = 1'b1; wait_n(16);
    rx_in = 1'b0; wait_n(8);
    chk("R6 short run then zero", int'(separator_ok), 0);
    chk("R7 fall before separator", start_cnt - s0, 0);
    rx_in = 1'b1; wait_n(24);
    rx_in = 1'b0; wait_n(6);
    chk("R6 full run after restart", int'(separator_ok), 1);
    chk("R7 start after full run", start_cnt - s0, 1);
  endtask

  task automatic t_early_and_restart();
    int r0;
    reopen();
    r0 = rej_cnt;
    train(16, 2);
    train(8, 1);
    train(16, 1);
    chk("R3 early edge rejected", rej_cnt - r0, 1);
    chk("R3 no preamble after early", int'(preamble_ok), 0);
    train(16, 3);
    chk("R5 count cleared after reject", int'(preamble_ok), 0);
    train(16, 1);
    chk("R5 fresh n edges accepted", int'(preamble_ok), 1);
    chk("R5 single reject pulse", rej_cnt - r0, 1);
  endtask

  task automatic t_late();
    int r0;
    reopen();
    r0 = rej_cnt;
    train(16, 2);
    wait_n(30);
    chk("R4 silent gap rejected", rej_cnt - r0, 1);
    chk("R4 no preamble after gap", int'(preamble_ok), 0);
  endtask

  task automatic t_window_limits();
    int r0;
    reopen();
    r0 = rej_cnt;
    train(12, 4);
    chk("R2 spacing at min accepted", int'(preamble_ok), 1);
    reopen();
    train(20, 4);
    chk("R2 spacing at max accepted", int'(preamble_ok), 1);
    chk("R2 no reject at limits", rej_cnt - r0, 0);
    reopen();
    r0 = rej_cnt;
    train(11, 2);
    wait_n(4);
    chk("R3 spacing min-1 rejected", rej_cnt - r0, 1);
    reopen();
    r0 = rej_cnt;
    train(21, 2);
    chk("R4 spacing max+1 rejected", (rej_cnt - r0) > 0 ? 1 : 0, 1);
    chk("R4 no preamble at max+1", int'(preamble_ok), 0);
  endtask

  initial begin
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_good_frame();
    t_short_separator();
    t_early_and_restart();
    t_late();
    t_window_limits();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule